// File: doc/BRIEF.md
# Language card bank mapper

This block translates processor accesses in the top 12 KB ($D000-$FFFF) of banks $00, $01, $E0 and $E1 into either a ROM read or a RAM access at a physical offset. It holds the soft-switch state that decides this mapping: where reads come from, whether writes are allowed, and which of two 4 KB pools the $D000-$DFFF window uses. The state changes when the processor touches any address whose bits [15:4] are $C08, in any bank.

The mapping itself is combinational from the access inputs and the registered switch state. A switch access changes the state at the next clock edge, so the new mapping applies to the access after it. Banks $E0 and $E1 share one slow-RAM store whose base is a parameter. Bank $00 can take its card RAM from the auxiliary 64 KB. An inhibit input removes the card from banks $00 and $01 and shows plain RAM there.

Top module: `lc_bank_mapper`

## Requirements
- R1: An access outside the card window passes through unchanged: map_ram=1, map_off={bank,addr}, map_wen=acc_write. The card window is banks $00/$01/$E0/$E1 at addresses $D000-$FFFF.
- R2: In the $D000-$DFFF window, pool 2 maps to base+addr and pool 1 maps to base+addr-$1000. A switch access with address bit 3 = 0 selects pool 2 and bit 3 = 1 selects pool 1.
- R3: The $E000-$FFFF window maps to base+addr whichever pool is selected.
- R4: A switch access with address bits [1:0] = 00 or 11 makes window reads come from RAM (map_ram=1); 01 or 10 makes them come from ROM (map_ram=0, map_off=addr, an offset into the top ROM bank). Window writes always give map_ram=1.
- R5: Writes become enabled only after two consecutive odd-address switch reads. An even-address switch access protects writes and disarms the sequence. An odd-address switch write disarms it without changing protection.
- R6: While writes are protected, a window write gives map_wen=0. Otherwise map_wen=acc_write.
- R7: With the card active, the bank $00 card base is $010000 when zp_aux=1 and $000000 otherwise. The bank $01 base is $010000.
- R8: When lc_inhibit=1, banks $00/$01 show RAM at $D000-$FFFF with no pool or protection effects. Bank $00 uses base $010000 if the relevant main select is set (main_rd_aux for reads, main_wr_aux for writes). Bank $01 uses $010000.
- R9: Banks $E0 and $E1 both use base SLOW_BASE (default $7E0000), and lc_inhibit does not affect them.
- R10: After reset, reads come from ROM, writes are enabled but disarmed, and pool 2 is selected.
- R11: Only accesses with addr[15:4]=$C08 change the switch state, in any bank. The change is visible from the next cycle.
- R12: map_wen is 0 whenever acc_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_bank | input | 8 | Bank of the access |
| acc_addr | input | 16 | Address within the bank |
| acc_write | input | 1 | 1 = write, 0 = read |
| zp_aux | input | 1 | Auxiliary zero-page/card select for bank $00 |
| main_rd_aux | input | 1 | Main-area reads from auxiliary memory |
| main_wr_aux | input | 1 | Main-area writes to auxiliary memory |
| lc_inhibit | input | 1 | Removes the card from banks $00/$01 |
| map_ram | output | 1 | 1 = RAM, 0 = ROM |
| map_wen | output | 1 | RAM write enable |
| map_off | output | OFF_W | Physical RAM offset, or ROM offset when map_ram=0 |

## Verification
The hardest state to reach is the write-arming sequence. Only an unbroken pair of odd-address switch reads may lift protection, and a switch write in between must break the pair without protecting anything. The bench first protects writes with an even access. It then sends odd read, odd write, odd read, and checks that a window write is still refused. One more odd read must then enable the write. Each step of the sequence is observed through the map_wen result of a window write.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
    typedef struct packed {
        logic rd_ram;   // window reads from RAM
        logic wprot;    // window writes discarded
        logic armed;    // one odd read seen
        logic pool2;    // $D000 window uses pool 2
    } lc_state_t;

    localparam lc_state_t LC_RESET = '{rd_ram: 1'b0, wprot: 1'b0, armed: 1'b0, pool2: 1'b1};
endpackage

// File: rtl/lcm_switch.sv
module lcm_switch
    import lcm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      is_write,
    input  logic      a3,
    input  logic [1:0] a10,
    output lc_state_t st_q
);
    lc_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.rd_ram = (a10 == 2'b00) || (a10 == 2'b11);
            st_d.pool2  = ~a3;
            if (!a10[0]) begin
                st_d.wprot = 1'b1;
                st_d.armed = 1'b0;
            end else if (!is_write) begin
                if (st_q.armed) st_d.wprot = 1'b0;
                st_d.armed = 1'b1;
            end else begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LC_RESET;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcm_xlate.sv
module lcm_xlate
    import lcm_pkg::*;
#(
    parameter int OFF_W = 24,
    parameter logic [OFF_W-1:0] SLOW_BASE = 24'h7E0000
) (
    input  logic             acc_valid,
    input  logic [7:0]       acc_bank,
    input  logic [15:0]      acc_addr,
    input  logic             acc_write,
    input  logic             zp_aux,
    input  logic             main_rd_aux,
    input  logic             main_wr_aux,
    input  logic             lc_inhibit,
    input  lc_state_t        st,
    output logic             map_ram,
    output logic             map_wen,
    output logic [OFF_W-1:0] map_off
);
    localparam logic [OFF_W-1:0] AUX_BASE  = OFF_W'(32'h0001_0000);
    localparam logic [OFF_W-1:0] POOL_STEP = OFF_W'(32'h0000_1000);

    logic             lc_bank, in_win, low_win, slow_bank;
    logic [OFF_W-1:0] base, addr_ext;

    always_comb begin
        lc_bank   = (acc_bank == 8'h00) || (acc_bank == 8'h01) ||
                    (acc_bank == 8'hE0) || (acc_bank == 8'hE1);
        slow_bank = acc_bank[7];
        in_win    = lc_bank && (acc_addr[15:12] >= 4'hD);
        low_win   = (acc_addr[15:12] == 4'hD);
        addr_ext  = OFF_W'(acc_addr);
        base      = '0;
        map_ram   = 1'b1;
        map_wen   = acc_valid && acc_write;
        map_off   = OFF_W'({acc_bank, acc_addr});
        if (in_win) begin
            if (slow_bank)
                base = SLOW_BASE;
            else if (acc_bank[0])
                base = AUX_BASE;
            else if (lc_inhibit)
                base = (acc_write ? main_wr_aux : main_rd_aux) ? AUX_BASE : '0;
            else
                base = zp_aux ? AUX_BASE : '0;

            if (lc_inhibit && !slow_bank) begin
                map_off = base + addr_ext;
            end else begin
                map_off = base + addr_ext - ((low_win && !st.pool2) ? POOL_STEP : '0);
                map_wen = acc_valid && acc_write && !st.wprot;
                if (!acc_write && !st.rd_ram) begin
                    map_ram = 1'b0;
                    map_off = addr_ext;
                end
            end
        end
    end
endmodule

// File: rtl/lc_bank_mapper.sv
module lc_bank_mapper
    import lcm_pkg::*;
#(
    parameter int OFF_W = 24,
    parameter logic [OFF_W-1:0] SLOW_BASE = 24'h7E0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [7:0]       acc_bank,
    input  logic [15:0]      acc_addr,
    input  logic             acc_write,
    input  logic             zp_aux,
    input  logic             main_rd_aux,
    input  logic             main_wr_aux,
    input  logic             lc_inhibit,
    output logic             map_ram,
    output logic             map_wen,
    output logic [OFF_W-1:0] map_off
);
    lc_state_t st_q;
    logic      sw_hit;

    assign sw_hit = acc_valid && (acc_addr[15:4] == 12'hC08);

    lcm_switch u_switch (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (sw_hit),
        .is_write (acc_write),
        .a3       (acc_addr[3]),
        .a10      (acc_addr[1:0]),
        .st_q     (st_q)
    );

    lcm_xlate #(.OFF_W(OFF_W), .SLOW_BASE(SLOW_BASE)) u_xlate (
        .acc_valid   (acc_valid),
        .acc_bank    (acc_bank),
        .acc_addr    (acc_addr),
        .acc_write   (acc_write),
        .zp_aux      (zp_aux),
        .main_rd_aux (main_rd_aux),
        .main_wr_aux (main_wr_aux),
        .lc_inhibit  (lc_inhibit),
        .st          (st_q),
        .map_ram     (map_ram),
        .map_wen     (map_wen),
        .map_off     (map_off)
    );
endmodule

// File: rtl/lcm_chk.sv
module lcm_chk #(
    parameter int OFF_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [7:0]       acc_bank,
    input logic [15:0]      acc_addr,
    input logic             acc_write,
    input logic             map_ram,
    input logic             map_wen,
    input logic [OFF_W-1:0] map_off,
    input logic             wprot,
    input logic             armed
);
    logic lc_bank, sw_acc;
    assign lc_bank = (acc_bank == 8'h00) || (acc_bank == 8'h01) ||
                     (acc_bank == 8'hE0) || (acc_bank == 8'hE1);
    assign sw_acc  = acc_valid && (acc_addr[15:4] == 12'hC08);

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !lc_bank) |-> (map_ram && map_off == OFF_W'({acc_bank, acc_addr}))); // R1

    AST_EVEN_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_acc && !acc_addr[0]) |=> (wprot && !armed)); // R5

    AST_SECOND_ODD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_acc && acc_addr[0] && !acc_write && armed) |=> !wprot); // R5

    AST_WEN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        map_wen |-> (acc_valid && acc_write)); // R12

    AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_acc |=> ($stable(wprot) && $stable(armed))); // R11

    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && wprot && acc_bank[7] && lc_bank && acc_addr[15:12] >= 4'hD) |-> !map_wen); // R6
endmodule

bind lc_bank_mapper lcm_chk #(.OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_bank  (acc_bank),
    .acc_addr  (acc_addr),
    .acc_write (acc_write),
    .map_ram   (map_ram),
    .map_wen   (map_wen),
    .map_off   (map_off),
    .wprot     (st_q.wprot),
    .armed     (st_q.armed)
);

// File: tb/lc_bank_mapper_tb.sv
module lc_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_bank = '0;
    logic [15:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        zp_aux = 1'b0, main_rd_aux = 1'b0, main_wr_aux = 1'b0, lc_inhibit = 1'b0;
    logic        map_ram, map_wen;
    logic [23:0] map_off;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    lc_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_bank(acc_bank),
        .acc_addr(acc_addr), .acc_write(acc_write), .zp_aux(zp_aux),
        .main_rd_aux(main_rd_aux), .main_wr_aux(main_wr_aux), .lc_inhibit(lc_inhibit),
        .map_ram(map_ram), .map_wen(map_wen), .map_off(map_off)
    );

    task automatic probe(input string req, input logic [7:0] b, input logic [15:0] a,
                         input logic w, input logic e_ram, input logic e_wen,
                         input logic [23:0] e_off);
        @(negedge clk);
        acc_valid = 1'b1; acc_bank = b; acc_addr = a; acc_write = w;
        #1;
        n_chk++;
        if (map_ram !== e_ram || map_wen !== e_wen || map_off !== e_off) begin
            n_bad++;
            $display("FAIL %s: bank %h addr %h wr %0b got ram=%0b wen=%0b off=%h exp ram=%0b wen=%0b off=%h",
                     req, b, a, w, map_ram, map_wen, map_off, e_ram, e_wen, e_off);
        end
        acc_valid = 1'b0;
    endtask

    task automatic sw(input logic [7:0] b, input logic [15:0] a, input logic w);
        @(negedge clk);
        acc_valid = 1'b1; acc_bank = b; acc_addr = a; acc_write = w;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic t_reset;
        probe("R10 rom after reset", 8'hE0, 16'hD000, 1'b0, 1'b0, 1'b0, 24'h00D000);
        probe("R10 write enabled pool2", 8'hE0, 16'hD000, 1'b1, 1'b1, 1'b1, 24'h7ED000);
    endtask

    task automatic t_pass;
        probe("R1 other bank read", 8'h05, 16'hD000, 1'b0, 1'b1, 1'b0, 24'h05D000);
        probe("R1 other bank write", 8'h05, 16'hE123, 1'b1, 1'b1, 1'b1, 24'h05E123);
        probe("R1 low address", 8'h00, 16'h1234, 1'b0, 1'b1, 1'b0, 24'h001234);
        @(negedge clk); acc_valid = 1'b0; acc_bank = 8'h05; acc_addr = 16'h2000; acc_write = 1'b1; #1;
        n_chk++;
        if (map_wen !== 1'b0) begin n_bad++; $display("FAIL R12: wen=%0b exp 0", map_wen); end
        acc_write = 1'b0;
    endtask

    task automatic t_read_src;
        sw(8'h00, 16'hC080, 1'b0);
        probe("R4 ram read 00", 8'hE0, 16'hD010, 1'b0, 1'b1, 1'b0, 24'h7ED010);
        sw(8'h00, 16'hC081, 1'b0);
        probe("R4 rom read 01", 8'hE0, 16'hD010, 1'b0, 1'b0, 1'b0, 24'h00D010);
        sw(8'h00, 16'hC083, 1'b0);
        probe("R4 ram read 11", 8'hE0, 16'hFFF0, 1'b0, 1'b1, 1'b0, 24'h7EFFF0);
    endtask

    task automatic t_pool;
        sw(8'h00, 16'hC08B, 1'b0);
        probe("R2 pool1 E1", 8'hE1, 16'hD020, 1'b0, 1'b1, 1'b0, 24'h7EC020);
        probe("R9 pool1 E0 alias", 8'hE0, 16'hD020, 1'b0, 1'b1, 1'b0, 24'h7EC020);
        probe("R3 upper window pool1", 8'hE0, 16'hE456, 1'b0, 1'b1, 1'b0, 24'h7EE456);
        probe("R2 pool1 bank01", 8'h01, 16'hD000, 1'b0, 1'b1, 1'b0, 24'h01C000);
        sw(8'h00, 16'hC083, 1'b0);
        probe("R3 upper window pool2", 8'hE1, 16'hE456, 1'b0, 1'b1, 1'b0, 24'h7EE456);
        probe("R2 pool2 bank01", 8'h01, 16'hD000, 1'b0, 1'b1, 1'b0, 24'h01D000);
    endtask

    task automatic t_wprot;
        sw(8'h00, 16'hC080, 1'b0);
        probe("R6 protected write", 8'hE0, 16'hD000, 1'b1, 1'b1, 1'b0, 24'h7ED000);
        sw(8'h00, 16'hC081, 1'b0);
        probe("R5 one odd read", 8'hE0, 16'hD000, 1'b1, 1'b1, 1'b0, 24'h7ED000);
        sw(8'h00, 16'hC081, 1'b0);
        probe("R5 two odd reads", 8'hE0, 16'hD000, 1'b1, 1'b1, 1'b1, 24'h7ED000);
        sw(8'h00, 16'hC080, 1'b0);
        sw(8'h00, 16'hC081, 1'b0);
        sw(8'h00, 16'hC081, 1'b1);
        sw(8'h00, 16'hC081, 1'b0);
        probe("R5 odd write breaks pair", 8'hE1, 16'hF000, 1'b1, 1'b1, 1'b0, 24'h7EF000);
        sw(8'h00, 16'hC081, 1'b0);
        probe("R5 pair after break", 8'hE1, 16'hF000, 1'b1, 1'b1, 1'b1, 24'h7EF000);
    endtask

    task automatic t_zp;
        sw(8'h00, 16'hC083, 1'b0);
        zp_aux = 1'b1;
        probe("R7 bank00 aux", 8'h00, 16'hD100, 1'b0, 1'b1, 1'b0, 24'h01D100);
        zp_aux = 1'b0;
        probe("R7 bank00 main", 8'h00, 16'hD100, 1'b0, 1'b1, 1'b0, 24'h00D100);
    endtask

    task automatic t_inhibit;
        sw(8'h00, 16'hC08A, 1'b0);
        lc_inhibit = 1'b1; main_rd_aux = 1'b1; main_wr_aux = 1'b0;
        probe("R8 bank00 read aux", 8'h00, 16'hD100, 1'b0, 1'b1, 1'b0, 24'h01D100);
        probe("R8 bank00 write main", 8'h00, 16'hD100, 1'b1, 1'b1, 1'b1, 24'h00D100);
        probe("R8 bank01 plain", 8'h01, 16'hF000, 1'b0, 1'b1, 1'b0, 24'h01F000);
        probe("R9 E0 unaffected", 8'hE0, 16'hD000, 1'b0, 1'b0, 1'b0, 24'h00D000);
        lc_inhibit = 1'b0; main_rd_aux = 1'b0;
    endtask

    task automatic t_other_bank_sw;
        sw(8'h33, 16'hC093, 1'b0);
        probe("R11 non-switch ignored", 8'hE0, 16'hD000, 1'b0, 1'b0, 1'b0, 24'h00D000);
        sw(8'h33, 16'hC083, 1'b0);
        probe("R11 switch from any bank", 8'hE0, 16'hD000, 1'b0, 1'b1, 1'b0, 24'h7ED000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pass();
        t_read_src();
        t_pool();
        t_wprot();
        t_zp();
        t_inhibit();
        t_other_bank_sw();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule